// File: doc/BRIEF.md
# Cascadable Counter Channels with Module-Wide Snapshot

This block holds a small group of up-counter channels that share one count enable. Each channel runs free on that enable, stops, follows another channel's wrap one clock late, or joins a partner as the upper word of a synchronous double-width count. In the double-width case the upper channel steps on the very edge at which its partner rolls over. The block checks cascade requests against a depth rule. A request that would make a chain longer than two channels, or that loops, falls back to free counting.

A single read port returns either a channel's live value or its held copy. Any live read copies every channel into its own held register on the same edge. Software reads one word of a chain live and then reads the other word from its held copy, so the two words always belong to the same instant. The read response has no back-pressure: it appears with `rd_valid` one cycle after `rd_en` and must be taken in that cycle. One request may be issued per cycle.

Top module: `casc_counter`

## Requirements
- R1: After reset every counter and every held copy is zero, `rd_data` is zero and `rd_valid` is low.
- R2: A channel in free mode (mode code 00) adds one on every clock edge at which `cnt_en` is high and wraps from all-ones to zero.
- R3: `carry_o[c]` is high during exactly the cycle whose closing edge takes channel c from all-ones to zero. It is low while the channel sits at all-ones without advancing.
- R4: An accepted channel in cascade mode (code 01) adds one on the same edge at which its source channel (selected by its `src_i` field) wraps, and it holds on every other edge. The two channels together form a count of twice the width.
- R5: A channel in ripple mode (code 10) adds one on the edge that follows the edge at which its source wrapped, whether or not `cnt_en` is high.
- R6: A channel in stop mode (code 11) keeps its value.
- R7: A cascade request is rejected when its source is itself requesting cascade, or when the source is the channel itself. This covers a third channel joining a pair and covers loops. A rejected channel counts as in free mode.
- R8: When several channels request cascade on the same source, only the lowest-numbered one is accepted. The others count as in free mode.
- R9: A read with `rd_hold` low returns, one cycle later with `rd_valid` high, the value that channel `rd_idx` held at the read edge.
- R10: A live read copies the value of every channel at that same edge into that channel's held register.
- R11: A read with `rd_hold` high returns the held copy of channel `rd_idx` and changes no held register. Held registers change only on a live read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Shared count enable |
| mode_i | input | 2*NUM_CH | Per-channel mode: bits [2c+1:2c] for channel c (00 free, 01 cascade, 10 ripple, 11 stop) |
| src_i | input | IW*NUM_CH | Per-channel source channel index: bits [IW*c+IW-1:IW*c] |
| rd_en | input | 1 | Read request |
| rd_hold | input | 1 | 0 reads the live counter, 1 reads the held copy |
| rd_idx | input | IW | Channel to read |
| rd_data | output | WIDTH | Read result |
| rd_valid | output | 1 | Read result valid, one cycle after `rd_en` |
| carry_o | output | NUM_CH | Per-channel wrap pulse |

## Verification
The hardest state to reach from the ports is the one-cycle gap between a ripple follower and a cascaded partner after the same wrap. The gap lasts a single edge, and any read needs an edge of its own. The bench advances the source to all-ones, gives one enabled edge, and then spends the next edge on a live read of the cascaded channel. That read snapshots the ripple channel just before its late step, so its held copy still shows the old value while a second live read shows the new one. Rejection cases are set up with three channels, so that the third member of a chain, a mutual pair, a self-source and two claims on one source can each be observed counting freely.

// File: rtl/ctr_pair_pkg.sv
package ctr_pair_pkg;
  typedef enum logic [1:0] {
    MODE_FREE = 2'b00,
    MODE_CASC = 2'b01,
    MODE_RIPL = 2'b10,
    MODE_STOP = 2'b11
  } ch_mode_e;
endpackage

// File: rtl/ctr_cascade_arb.sv
module ctr_cascade_arb
  import ctr_pair_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int IW     = 1
) (
  input  logic [2*NUM_CH-1:0]  mode_i,
  input  logic [IW*NUM_CH-1:0] src_i,
  output logic [NUM_CH-1:0]    casc_ok_o
);
  logic [NUM_CH-1:0] req;

  function automatic logic [IW-1:0] src_of(input int c);
    return src_i[c*IW +: IW];
  endfunction

  function automatic logic in_range(input logic [IW-1:0] s);
    return ({{(32-IW){1'b0}}, s} < 32'(NUM_CH));
  endfunction

  // A request is kept only when its source is a plain channel (not an upper
  // word itself) and no lower-numbered channel already claimed that source.
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      req[c] = (ch_mode_e'(mode_i[2*c +: 2]) == MODE_CASC) &&
               in_range(src_of(c)) && ({{(32-IW){1'b0}}, src_of(c)} != 32'(c));
    end
    for (int c = 0; c < NUM_CH; c++) begin
      casc_ok_o[c] = req[c];
      if (req[c] && req[src_of(c)]) casc_ok_o[c] = 1'b0;
      for (int j = 0; j < c; j++) begin
        if (req[j] && (src_of(j) == src_of(c))) casc_ok_o[c] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/ctr_channel.sv
module ctr_channel #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             at_max_o
);
  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o    = cnt_q;
  assign at_max_o = &cnt_q;

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    inc_i |=> cnt_q == $past(cnt_q) + 1'b1); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_i |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/ctr_snapshot.sv
module ctr_snapshot #(
  parameter int NUM_CH = 2,
  parameter int WIDTH  = 16,
  parameter int IW     = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_en,
  input  logic                    rd_hold,
  input  logic [IW-1:0]           rd_idx,
  input  logic [NUM_CH*WIDTH-1:0] cnt_i,
  output logic [WIDTH-1:0]        rd_data,
  output logic                    rd_valid
);
  logic [WIDTH-1:0] hold_q [NUM_CH];
  logic [WIDTH-1:0] sel;
  logic             live;
  logic             idx_ok;

  assign live   = rd_en && !rd_hold;
  assign idx_ok = ({{(32-IW){1'b0}}, rd_idx} < 32'(NUM_CH));

  always_comb begin
    sel = '0;
    if (idx_ok) sel = rd_hold ? hold_q[rd_idx] : cnt_i[rd_idx*WIDTH +: WIDTH];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) hold_q[i] <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= sel;
      if (live) begin
        for (int i = 0; i < NUM_CH; i++) hold_q[i] <= cnt_i[i*WIDTH +: WIDTH];
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    AST_SNAP_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      live |=> hold_q[g] == $past(cnt_i[g*WIDTH +: WIDTH])); // R10
    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !live |=> $stable(hold_q[g])); // R11
  end
endmodule

// File: rtl/casc_counter.sv
module casc_counter
  import ctr_pair_pkg::*;
#(
  parameter  int NUM_CH = 2,
  parameter  int WIDTH  = 16,
  localparam int IW     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cnt_en,
  input  logic [2*NUM_CH-1:0]    mode_i,
  input  logic [IW*NUM_CH-1:0]   src_i,
  input  logic                   rd_en,
  input  logic                   rd_hold,
  input  logic [IW-1:0]          rd_idx,
  output logic [WIDTH-1:0]       rd_data,
  output logic                   rd_valid,
  output logic [NUM_CH-1:0]      carry_o
);
  logic [NUM_CH-1:0]       casc_ok;
  logic [NUM_CH-1:0]       base_inc;
  logic [NUM_CH-1:0]       inc;
  logic [NUM_CH-1:0]       at_max;
  logic [NUM_CH-1:0]       carry;
  logic [NUM_CH-1:0]       carry_q;
  logic [NUM_CH*WIDTH-1:0] cnt_flat;

  function automatic logic [IW-1:0] src_of(input int c);
    return src_i[c*IW +: IW];
  endfunction

  function automatic logic in_range(input logic [IW-1:0] s);
    return ({{(32-IW){1'b0}}, s} < 32'(NUM_CH));
  endfunction

  ctr_cascade_arb #(.NUM_CH(NUM_CH), .IW(IW)) u_arb (
    .mode_i   (mode_i),
    .src_i    (src_i),
    .casc_ok_o(casc_ok)
  );

  // Enables are built in two passes: first without cascade, then an accepted
  // upper word takes its source's first-pass enable gated by the source's max.
  // An accepted source never cascades, so the first pass is final for it.
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      unique case (ch_mode_e'(mode_i[2*c +: 2]))
        MODE_FREE, MODE_CASC: base_inc[c] = cnt_en;
        MODE_RIPL:            base_inc[c] = in_range(src_of(c)) && carry_q[src_of(c)];
        default:              base_inc[c] = 1'b0;
      endcase
    end
    for (int c = 0; c < NUM_CH; c++) begin
      inc[c] = casc_ok[c] ? (base_inc[src_of(c)] && at_max[src_of(c)]) : base_inc[c];
    end
    carry = inc & at_max;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) carry_q <= '0;
    else        carry_q <= carry;
  end

  assign carry_o = carry;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    ctr_channel #(.WIDTH(WIDTH)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_i   (inc[g]),
      .cnt_o   (cnt_flat[g*WIDTH +: WIDTH]),
      .at_max_o(at_max[g])
    );

    AST_CASCADE_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
      (casc_ok[g] && carry[src_i[g*IW +: IW]]) |=>
        cnt_flat[g*WIDTH +: WIDTH] == $past(cnt_flat[g*WIDTH +: WIDTH]) + 1'b1); // R4
    AST_CASCADE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (casc_ok[g] && !carry[src_i[g*IW +: IW]]) |=>
        $stable(cnt_flat[g*WIDTH +: WIDTH])); // R4
    AST_PAIR_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
      casc_ok[g] |-> !casc_ok[src_i[g*IW +: IW]]); // R7
    AST_STOP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i[2*g +: 2] == MODE_STOP) |=> $stable(cnt_flat[g*WIDTH +: WIDTH])); // R6
    AST_CARRY_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
      carry[g] |=> cnt_flat[g*WIDTH +: WIDTH] == '0); // R3
  end

  for (genvar a = 0; a < NUM_CH; a++) begin : g_uniq
    for (genvar b = a + 1; b < NUM_CH; b++) begin : g_pair
      AST_ONE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (casc_ok[a] && casc_ok[b]) |-> src_i[a*IW +: IW] != src_i[b*IW +: IW]); // R8
    end
  end

  ctr_snapshot #(.NUM_CH(NUM_CH), .WIDTH(WIDTH), .IW(IW)) u_snap (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_hold (rd_hold),
    .rd_idx  (rd_idx),
    .cnt_i   (cnt_flat),
    .rd_data (rd_data),
    .rd_valid(rd_valid)
  );
endmodule

// File: tb/casc_counter_bench.sv
module casc_counter_bench;
  localparam int NCH = 3;
  localparam int W   = 4;
  localparam int M   = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cnt_en = 1'b0;
  logic [5:0]   mode_i = '0;
  logic [5:0]   src_i = '0;
  logic         rd_en = 1'b0;
  logic         rd_hold = 1'b0;
  logic [1:0]   rd_idx = '0;
  logic [W-1:0] rd_data;
  logic         rd_valid;
  logic [NCH-1:0] carry_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  casc_counter #(.NUM_CH(NCH), .WIDTH(W)) u_casc_counter (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .mode_i(mode_i), .src_i(src_i),
    .rd_en(rd_en), .rd_hold(rd_hold), .rd_idx(rd_idx),
    .rd_data(rd_data), .rd_valid(rd_valid), .carry_o(carry_o)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; cnt_en = 1'b0; rd_en = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic cfg(input logic [1:0] m0, input logic [1:0] s0,
                     input logic [1:0] m1, input logic [1:0] s1,
                     input logic [1:0] m2, input logic [1:0] s2);
    mode_i = {m2, m1, m0};
    src_i  = {s2, s1, s0};
  endtask

  task automatic run(input int k);
    cnt_en = 1'b1;
    repeat (k) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic peek(input int idx, input bit hold, output int v);
    rd_en = 1'b1; rd_hold = hold; rd_idx = 2'(idx);
    @(negedge clk);
    rd_en = 1'b0;
    v = int'(rd_data);
    chk("R9 rd_valid after request", int'(rd_valid), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v;
    int t;
    // R1 reset state
    do_reset();
    cfg(2'b00, 2'd0, 2'b00, 2'd0, 2'b00, 2'd0);
    chk("R1 rd_valid", int'(rd_valid), 0);
    chk("R1 rd_data", int'(rd_data), 0);
    for (int i = 0; i < NCH; i++) begin
      peek(i, 1'b1, v); chk("R1 hold zero", v, 0);
    end
    for (int i = 0; i < NCH; i++) begin
      peek(i, 1'b0, v); chk("R1 live zero", v, 0);
    end
    @(negedge clk);
    chk("R9 rd_valid drops", int'(rd_valid), 0);

    // R2 free sweep
    t = 0;
    for (int k = 1; k <= 20; k++) begin
      run(k); t += k;
      for (int i = 0; i < NCH; i++) begin
        peek(i, 1'b0, v); chk("R2 free count", v, t % M);
      end
    end

    // R6 stop
    do_reset();
    cfg(2'b00, 2'd0, 2'b00, 2'd0, 2'b11, 2'd0);
    run(9);
    peek(2, 1'b0, v); chk("R6 stopped channel", v, 0);
    peek(0, 1'b0, v); chk("R6 free neighbour", v, 9);

    // R4 / R10 cascade sweep with consistent two-word read
    do_reset();
    cfg(2'b00, 2'd0, 2'b01, 2'd0, 2'b00, 2'd0);
    t = 0;
    for (int k = 0; k < 40; k++) begin
      run(7); t += 7;
      peek(0, 1'b0, v); chk("R4 lower word", v, t % M);
      peek(1, 1'b1, v); chk("R4 upper word from hold", v, (t / M) % M);
      peek(2, 1'b1, v); chk("R10 snapshot of free channel", v, t % M);
    end

    // R3 carry pulse and same-edge step
    do_reset();
    cfg(2'b00, 2'd0, 2'b01, 2'd0, 2'b11, 2'd0);
    run(M - 1);
    #1;
    chk("R3 carry low when idle at max", int'(carry_o[0]), 0);
    @(negedge clk);
    cnt_en = 1'b1;
    #1;
    chk("R3 carry high on wrapping cycle", int'(carry_o[0]), 1);
    chk("R3 upper carry low", int'(carry_o[1]), 0);
    @(negedge clk);
    cnt_en = 1'b0;
    #1;
    chk("R3 carry low after wrap", int'(carry_o[0]), 0);
    peek(0, 1'b0, v); chk("R3 lower wrapped", v, 0);
    peek(1, 1'b0, v); chk("R4 upper stepped on same edge", v, 1);

    // R5 ripple lags by one edge, cascade does not
    do_reset();
    cfg(2'b00, 2'd0, 2'b01, 2'd0, 2'b10, 2'd0);
    run(M - 1);
    run(1);
    peek(1, 1'b0, v); chk("R4 cascade already stepped", v, 1);
    peek(2, 1'b1, v); chk("R5 ripple not yet stepped", v, 0);
    peek(2, 1'b0, v); chk("R5 ripple stepped one edge later", v, 1);

    // R7 third member, mutual pair, self source
    do_reset();
    cfg(2'b00, 2'd0, 2'b01, 2'd0, 2'b01, 2'd1);
    run(20);
    peek(0, 1'b0, v); chk("R7 base lower", v, 20 % M);
    peek(1, 1'b0, v); chk("R7 accepted upper", v, 20 / M);
    peek(2, 1'b0, v); chk("R7 third member counts freely", v, 20 % M);
    do_reset();
    cfg(2'b01, 2'd1, 2'b01, 2'd0, 2'b01, 2'd2);
    run(7);
    peek(0, 1'b0, v); chk("R7 mutual ch0 free", v, 7);
    peek(1, 1'b0, v); chk("R7 mutual ch1 free", v, 7);
    peek(2, 1'b0, v); chk("R7 self source free", v, 7);

    // R8 two claims on one source
    do_reset();
    cfg(2'b00, 2'd0, 2'b01, 2'd0, 2'b01, 2'd0);
    run(18);
    peek(1, 1'b0, v); chk("R8 lowest claimant accepted", v, 1);
    peek(2, 1'b0, v); chk("R8 later claimant free", v, 18 % M);
    do_reset();
    cfg(2'b01, 2'd2, 2'b01, 2'd2, 2'b00, 2'd0);
    run(18);
    peek(0, 1'b0, v); chk("R8 ch0 wins source 2", v, 1);
    peek(1, 1'b0, v); chk("R8 ch1 free", v, 18 % M);

    // R11 holds survive counting and hold reads; R10 refresh
    do_reset();
    cfg(2'b00, 2'd0, 2'b00, 2'd0, 2'b00, 2'd0);
    run(5);
    peek(0, 1'b0, v); chk("R9 live read", v, 5);
    run(3);
    peek(1, 1'b1, v); chk("R11 hold kept", v, 5);
    peek(2, 1'b1, v); chk("R11 hold kept", v, 5);
    peek(1, 1'b1, v); chk("R11 hold read changes nothing", v, 5);
    peek(2, 1'b0, v); chk("R9 live read", v, 8);
    peek(0, 1'b1, v); chk("R10 refreshed hold", v, 8);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule